// File: doc/BRIEF.md
# Cascadable Configuration Loading Port

This block is the front end that takes a configuration bitstream into a programmable device. Data arrives in one of two ways. In serial mode one bit comes in on each configuration clock strobe, and eight bits form a byte, most significant bit first. In parallel mode a whole byte comes in on each write strobe. Every frame starts with a fixed marker byte. A two-byte payload length follows, high byte first, and then the payload bytes. Each payload byte goes into an internal configuration store at the next address in turn.

A verify input turns the payload phase into a comparison. In that mode each incoming byte is checked against the stored byte and nothing is written. When a device has taken all of its payload, it pulls its active-low cascade output low. That output selects the next device in a chain. Errors are reported on an open-drain style flag, modelled as a drive enable plus a constant low level, so that several devices can share one wired-OR line. An active-low start input frames each load.

Control is one state machine:
- IDLE is the state after reset and ignores data.
- Asserting start from any state moves the machine to PRE.
- PRE goes to CNT_HI on a correct marker, or to FAIL on any other byte.
- CNT_HI always goes to CNT_LO.
- CNT_LO goes to DATA when the length is nonzero, or to DONE when it is zero.
- DATA goes to DONE on the last payload byte.
- DONE and FAIL hold until start is asserted again.

Top module: `cascade_cfg_port`

## Requirements
- R1: With `par_mode`=1, each clock cycle in which `sel_n`=0, `start_n`=1 and `wr_n`=0 accepts the byte on `pdata`.
- R2: With `par_mode`=0, each cycle in which `sel_n`=0, `start_n`=1 and `ser_stb`=1 shifts in the bit on `ser_d`. Bits are taken most significant first, and every eighth bit completes a byte.
- R3: A frame is the marker byte 0xA5 (`MARKER`), then a 16-bit payload length sent high byte first, then that many payload bytes. Payload byte k is written to store address k and can be read back on `rd_data` at `rd_addr`=k.
- R4: If the first byte of a frame is not 0xA5, `err_oe` goes to 1 in the cycle after that byte. The rest of the frame is ignored: nothing is written and `casc_n` stays 1.
- R5: `casc_n` goes low in the cycle after the last payload byte, or after the low length byte when the length is zero. It stays low until `start_n` is asserted, and bytes received in the meantime are ignored.
- R6: While `check_n`=0, payload bytes are compared with the store and not written. A mismatch sets `err_oe`, and a match leaves it clear.
- R7: `err_oe` stays set until `start_n` is 0. A cycle with `start_n`=0 clears `err_oe`, releases `casc_n`, discards any partial serial byte and restarts at the marker. Data presented during that cycle is ignored.
- R8: While `sel_n`=1, no bytes or bits are accepted.
- R9: After reset the block sits in IDLE with `casc_n`=1, `err_oe`=0 and a store of all zeros. Bytes are ignored until the first cycle with `start_n`=0.
- R10: Payload bytes at index `MEM_DEPTH` or above still count toward the length, but they are neither stored nor compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_n | input | 1 | Active-low load start / framing |
| sel_n | input | 1 | Active-low device select |
| par_mode | input | 1 | 1 = byte-wide transfer, 0 = bit-serial |
| wr_n | input | 1 | Active-low byte write strobe (parallel) |
| pdata | input | DATA_W | Parallel data byte |
| ser_stb | input | 1 | Serial bit strobe, one per configuration clock |
| ser_d | input | 1 | Serial data bit |
| check_n | input | 1 | Active-low verify (compare instead of write) |
| rd_addr | input | ADDR_W | Store read address |
| casc_n | output | 1 | Active-low select for the next device in the chain |
| err_oe | output | 1 | Error line drive enable |
| err_lo | output | 1 | Level driven on the error line (always 0) |
| rd_data | output | DATA_W | Store contents at rd_addr |

## Verification
The bench builds the block with `MEM_DEPTH`=16, which keeps the store small enough for the bench's model to mirror completely. A 20-byte payload then runs past the end of the store, so the rule that bytes beyond the store are counted but dropped can be checked with both writing and verifying. The default `DATA_W` of 8 and the marker 0xA5 are kept, and the bench sends frames in both transfer modes with zero, short and overlong lengths.

// File: rtl/cascade_cfg_port_pkg.sv
package cascade_cfg_port_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_CNT_HI,
        ST_CNT_LO,
        ST_DATA,
        ST_DONE,
        ST_FAIL
    } cfg_state_t;
endpackage

// File: rtl/cascade_cfg_ser_asm.sv
module cascade_cfg_ser_asm #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic              bit_in,
    output logic              vld,
    output logic [DATA_W-1:0] byte_o
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    logic [DATA_W-2:0] shreg;
    logic [CNT_W-1:0]  bcnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            shreg <= '0;
            bcnt  <= '0;
        end else if (en) begin
            shreg <= {shreg[DATA_W-3:0], bit_in};
            bcnt  <= (bcnt == LAST) ? '0 : bcnt + 1'b1;
        end
    end

    assign vld    = en && (bcnt == LAST);
    assign byte_o = {shreg, bit_in};
endmodule

// File: rtl/cascade_cfg_store.sv
module cascade_cfg_store #(
    parameter int DATA_W    = 8,
    parameter int MEM_DEPTH = 64,
    parameter int ADDR_W    = $clog2(MEM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              cmp_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              mismatch
);
    logic [DATA_W-1:0] mem [MEM_DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[addr] <= wdata;
        end
    end

    assign rd_data  = mem[rd_addr];
    assign mismatch = cmp_en && (mem[addr] != wdata);
endmodule

// File: rtl/cascade_cfg_fsm.sv
module cascade_cfg_fsm
    import cascade_cfg_port_pkg::*;
#(
    parameter int              DATA_W    = 8,
    parameter int              MEM_DEPTH = 64,
    parameter int              ADDR_W    = $clog2(MEM_DEPTH),
    parameter logic [DATA_W-1:0] MARKER  = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_n,
    input  logic              check_n,
    input  logic              vld,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              mismatch,
    output logic              wr_en,
    output logic              cmp_en,
    output logic [ADDR_W-1:0] addr,
    output logic              casc_n,
    output logic              err_flag
);
    localparam int LEN_W = 2 * DATA_W;

    cfg_state_t       state, nxt;
    logic [DATA_W-1:0] len_hi;
    logic [LEN_W-1:0]  remain;
    logic [LEN_W-1:0]  idx;
    logic              in_range;
    logic [LEN_W-1:0]  len_full;

    assign len_full = {len_hi, byte_in};
    assign in_range = (int'(idx) < MEM_DEPTH);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        if (!start_n) begin
            nxt = ST_PRE;
        end else begin
            unique case (state)
                ST_IDLE:   nxt = ST_IDLE;
                ST_PRE:    if (vld) nxt = (byte_in == MARKER) ? ST_CNT_HI : ST_FAIL;
                ST_CNT_HI: if (vld) nxt = ST_CNT_LO;
                ST_CNT_LO: if (vld) nxt = (len_full == '0) ? ST_DONE : ST_DATA;
                ST_DATA:   if (vld && remain == LEN_W'(1)) nxt = ST_DONE;
                ST_DONE:   nxt = ST_DONE;
                ST_FAIL:   nxt = ST_FAIL;
                default:   nxt = ST_IDLE;
            endcase
        end
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_hi   <= '0;
            remain   <= '0;
            idx      <= '0;
            err_flag <= 1'b0;
        end else if (!start_n) begin
            idx      <= '0;
            err_flag <= 1'b0;
        end else begin
            if (vld && state == ST_CNT_HI) len_hi <= byte_in;
            if (vld && state == ST_CNT_LO) begin
                remain <= len_full;
                idx    <= '0;
            end
            if (vld && state == ST_DATA) begin
                remain <= remain - 1'b1;
                idx    <= idx + 1'b1;
            end
            if ((vld && state == ST_PRE && byte_in != MARKER) || mismatch)
                err_flag <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        wr_en  = start_n && vld && (state == ST_DATA) && check_n && in_range;
        cmp_en = start_n && vld && (state == ST_DATA) && !check_n && in_range;
        casc_n = (state != ST_DONE);
        addr   = idx[ADDR_W-1:0];
    end
endmodule

// File: rtl/cascade_cfg_port.sv
module cascade_cfg_port #(
    parameter int                DATA_W    = 8,
    parameter int                MEM_DEPTH = 64,
    parameter int                ADDR_W    = $clog2(MEM_DEPTH),
    parameter logic [DATA_W-1:0] MARKER    = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_n,
    input  logic              sel_n,
    input  logic              par_mode,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] pdata,
    input  logic              ser_stb,
    input  logic              ser_d,
    input  logic              check_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              casc_n,
    output logic              err_oe,
    output logic              err_lo,
    output logic [DATA_W-1:0] rd_data
);
    logic              ser_en, ser_vld, par_vld, byte_vld;
    logic [DATA_W-1:0] ser_byte, byte_in;
    logic              wr_en, cmp_en, mismatch, err_flag;
    logic [ADDR_W-1:0] addr;

    assign ser_en   = !par_mode && !sel_n && start_n && ser_stb;
    assign par_vld  = par_mode && !sel_n && start_n && !wr_n;
    assign byte_vld = par_mode ? par_vld : ser_vld;
    assign byte_in  = par_mode ? pdata : ser_byte;

    cascade_cfg_ser_asm #(.DATA_W(DATA_W)) u_ser (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (!start_n),
        .en     (ser_en),
        .bit_in (ser_d),
        .vld    (ser_vld),
        .byte_o (ser_byte)
    );

    cascade_cfg_fsm #(
        .DATA_W(DATA_W), .MEM_DEPTH(MEM_DEPTH), .ADDR_W(ADDR_W), .MARKER(MARKER)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_n  (start_n),
        .check_n  (check_n),
        .vld      (byte_vld),
        .byte_in  (byte_in),
        .mismatch (mismatch),
        .wr_en    (wr_en),
        .cmp_en   (cmp_en),
        .addr     (addr),
        .casc_n   (casc_n),
        .err_flag (err_flag)
    );

    cascade_cfg_store #(
        .DATA_W(DATA_W), .MEM_DEPTH(MEM_DEPTH), .ADDR_W(ADDR_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .cmp_en   (cmp_en),
        .addr     (addr),
        .wdata    (byte_in),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .mismatch (mismatch)
    );

    assign err_oe = err_flag;
    assign err_lo = 1'b0;
endmodule

// File: rtl/cascade_cfg_port_chk.sv
module cascade_cfg_port_chk (
    input logic clk,
    input logic rst_n,
    input logic start_n,
    input logic sel_n,
    input logic casc_n,
    input logic err_oe
);
    // R5: cascade select is held until a new start
    assert_done_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!casc_n && start_n) |=> !casc_n);

    // R7: error flag is sticky
    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_oe && start_n) |=> err_oe);

    // R7: start clears error and cascade select
    assert_start_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !start_n |=> (casc_n && !err_oe));

    // R8: a deselected device changes no visible state
    assert_desel_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n && start_n) |=> ($stable(casc_n) && $stable(err_oe)));
endmodule

bind cascade_cfg_port cascade_cfg_port_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_n (start_n),
    .sel_n   (sel_n),
    .casc_n  (casc_n),
    .err_oe  (err_oe)
);

// File: tb/cascade_cfg_port_tb_top.sv
`timescale 1ns/1ps
module cascade_cfg_port_tb_top;
    localparam int DEPTH = 16;
    localparam int P_IDLE = 0, P_PRE = 1, P_HI = 2, P_LO = 3, P_DATA = 4, P_DONE = 5, P_FAIL = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_n = 1'b1, sel_n = 1'b0, par_mode = 1'b1, wr_n = 1'b1;
    logic [7:0] pdata = '0;
    logic       ser_stb = 1'b0, ser_d = 1'b0, check_n = 1'b1;
    logic [3:0] rd_addr = '0;
    logic       casc_n, err_oe, err_lo;
    logic [7:0] rd_data;

    int checks = 0, fails = 0;
    bit finished = 0;

    // reference model
    int         ph = P_IDLE;
    bit         m_err = 0;
    logic [15:0] m_len, m_rem, m_idx;
    logic [7:0] m_mem [DEPTH];

    always #5 clk = ~clk;

    cascade_cfg_port #(.MEM_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_n(start_n), .sel_n(sel_n),
        .par_mode(par_mode), .wr_n(wr_n), .pdata(pdata), .ser_stb(ser_stb),
        .ser_d(ser_d), .check_n(check_n), .rd_addr(rd_addr),
        .casc_n(casc_n), .err_oe(err_oe), .err_lo(err_lo), .rd_data(rd_data)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic m_byte(input logic [7:0] b);
        case (ph)
            P_PRE:  if (b == 8'hA5) ph = P_HI; else begin ph = P_FAIL; m_err = 1; end
            P_HI:   begin m_len[15:8] = b; ph = P_LO; end
            P_LO:   begin
                m_len[7:0] = b; m_rem = m_len; m_idx = 0;
                ph = (m_len == 0) ? P_DONE : P_DATA;
            end
            P_DATA: begin
                if (m_idx < DEPTH) begin
                    if (!check_n) begin
                        if (m_mem[m_idx] != b) m_err = 1;
                    end else m_mem[m_idx] = b;
                end
                m_idx++; m_rem--;
                if (m_rem == 0) ph = P_DONE;
            end
            default: ;
        endcase
    endtask

    // compare outputs with the model on every clock
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(casc_n === ((ph == P_DONE) ? 1'b0 : 1'b1), "R5 casc_n", casc_n, (ph == P_DONE) ? 0 : 1);
            check(err_oe === m_err, "R7 err_oe", err_oe, m_err);
            check(err_lo === 1'b0, "R4 err_lo level", err_lo, 0);
        end
    end

    task automatic pulse_start();
        @(negedge clk); start_n = 1'b0;
        @(posedge clk); #1; ph = P_PRE; m_err = 0; start_n = 1'b1;
    endtask

    task automatic par_byte(input logic [7:0] b);
        @(negedge clk); par_mode = 1'b1; pdata = b; wr_n = 1'b0;
        @(posedge clk); #1; wr_n = 1'b1;
        if (!sel_n && start_n) m_byte(b);
    endtask

    task automatic ser_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk); par_mode = 1'b0; ser_d = b[i]; ser_stb = 1'b1;
            @(posedge clk); #1; ser_stb = 1'b0;
        end
        if (!sel_n && start_n) m_byte(b);
    endtask

    task automatic mem_chk(input int a, input string tag);
        @(negedge clk); rd_addr = 4'(a); #1;
        check(rd_data === m_mem[a], tag, rd_data, m_mem[a]);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog act=1 exp=0");
        finish_run();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(casc_n === 1'b1 && err_oe === 1'b0, "R9 reset outputs", {casc_n, err_oe}, 2'b10);

        // R9: ignored before first start
        par_byte(8'hA5); par_byte(8'h00); par_byte(8'h01); par_byte(8'h77);
        mem_chk(0, "R9 idle ignores data");

        // R1 R3: parallel frame
        pulse_start();
        par_byte(8'hA5); par_byte(8'h00); par_byte(8'h04);
        par_byte(8'h11); par_byte(8'h22); par_byte(8'h33); par_byte(8'h44);
        @(negedge clk);
        check(casc_n === 1'b0, "R5 cascade after last byte", casc_n, 0);
        for (int i = 0; i < 4; i++) mem_chk(i, "R1 R3 parallel payload");
        // R5: bytes after done ignored
        par_byte(8'h99); par_byte(8'h98);
        mem_chk(4, "R5 done ignores data");

        // R2: serial frame
        pulse_start();
        ser_byte(8'hA5); ser_byte(8'h00); ser_byte(8'h03);
        ser_byte(8'h5A); ser_byte(8'hC3); ser_byte(8'h0F);
        for (int i = 0; i < 3; i++) mem_chk(i, "R2 serial payload");

        // R6: verify matching
        pulse_start(); check_n = 1'b0;
        par_byte(8'hA5); par_byte(8'h00); par_byte(8'h03);
        par_byte(8'h5A); par_byte(8'hC3); par_byte(8'h0F);
        @(negedge clk);
        check(err_oe === 1'b0, "R6 verify match no error", err_oe, 0);
        // R6: verify mismatch
        pulse_start();
        par_byte(8'hA5); par_byte(8'h00); par_byte(8'h02);
        par_byte(8'h5A); par_byte(8'h00);
        @(negedge clk);
        check(err_oe === 1'b1, "R6 verify mismatch error", err_oe, 1);
        mem_chk(1, "R6 verify no write");
        check_n = 1'b1;
        par_byte(8'h12);
        @(negedge clk);
        check(err_oe === 1'b1, "R7 error sticky", err_oe, 1);

        // R4: bad marker
        pulse_start();
        par_byte(8'h3C);
        @(negedge clk);
        check(err_oe === 1'b1, "R4 bad marker error", err_oe, 1);
        par_byte(8'h00); par_byte(8'h01); par_byte(8'h77);
        mem_chk(0, "R4 frame abandoned");
        check(casc_n === 1'b1, "R4 no cascade", casc_n, 1);

        // R7: start clears, data during start ignored
        @(negedge clk); start_n = 1'b0; par_mode = 1'b1; pdata = 8'h3C; wr_n = 1'b0;
        @(posedge clk); #1; ph = P_PRE; m_err = 0; start_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
        check(err_oe === 1'b0, "R7 start clears error", err_oe, 0);

        // R8: deselected
        sel_n = 1'b1;
        par_byte(8'hA5); par_byte(8'h00); par_byte(8'h01); par_byte(8'h55);
        ser_byte(8'h3C);
        @(negedge clk);
        check(casc_n === 1'b1 && err_oe === 1'b0, "R8 deselect ignored", {casc_n, err_oe}, 2'b10);
        sel_n = 1'b0;
        // zero-length frame
        par_byte(8'hA5); par_byte(8'h00); par_byte(8'h00);
        @(negedge clk);
        check(casc_n === 1'b0, "R5 zero length done", casc_n, 0);

        // R10: overlong payload
        pulse_start();
        par_byte(8'hA5); par_byte(8'h00); par_byte(8'h14);
        for (int i = 0; i < 20; i++) par_byte(8'(8'h80 + i));
        @(negedge clk);
        check(casc_n === 1'b0, "R10 counted past store", casc_n, 0);
        for (int i = 0; i < DEPTH; i++) mem_chk(i, "R10 stored part");
        pulse_start(); check_n = 1'b0;
        par_byte(8'hA5); par_byte(8'h00); par_byte(8'h14);
        for (int i = 0; i < 20; i++) par_byte((i < DEPTH) ? 8'(8'h80 + i) : 8'h00);
        @(negedge clk);
        check(err_oe === 1'b0, "R10 no compare past store", err_oe, 0);
        check_n = 1'b1;

        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule